// File: doc/BRIEF.md
# Key Input Interrupt Controller

This block serves a small general-purpose input port of key lines. Each line passes through a synchronizer. Software reads the line levels through a narrow register bus. A per-line enable mask chooses which lines may raise an interrupt. When an enabled line becomes active, a single shared event flag is set. The flag drives an interrupt request toward the processor core, gated by the core's global interrupt enable.

The event flag is read and cleared in one access. It is also set when software enables a line that is already active. That case covers a key that was pressed before its interrupt was allowed. A separate wake output reports activity on enabled lines with no register stage after the synchronizer. A clock-stopped power state can use it to restart the oscillator. No other source in the device can end that state.

Top module: `kin_irq_ctrl`

## Requirements
- R1: A read with `addr` = 0 returns the pin levels on `rdata[3:0]`, bit i for pin i. A pin change becomes visible after two rising clock edges. While `rd_en` is low, `rdata` is 0.
- R2: A write with `addr` = 1 loads the enable mask from `wdata`, bit i enabling pin i. A read with `addr` = 1 returns the mask.
- R3: A pin that goes from 0 to 1 while its mask bit is 1 sets the event flag. The flag is set at the third rising edge after the pin change. The same change on a pin whose mask bit is 0 leaves the flag unchanged.
- R4: A mask write sets the flag at that write's clock edge if any pin enabled by the new mask value is already at 1.
- R5: A read with `addr` = 2 returns the flag on `rdata[0]`, with the upper bits 0, and clears the flag at that edge.
- R6: If a set event falls on the same edge as a flag read, the flag is 1 after that edge.
- R7: `irq_o` is 1 exactly when the flag is 1, `gie` is 1, and at least one mask bit is 1.
- R8: `wake_o` is 1 whenever a synchronized pin level is 1 and its mask bit is 1. No clock edge is needed after the synchronizer output.
- R9: After reset, the mask, the flag, `irq_o` and `wake_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 4 | Key input lines, active high, asynchronous |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 pins, 1 mask, 2 flag |
| wdata | input | 4 | Write data |
| rdata | output | 4 | Read data |
| gie | input | 1 | Global interrupt enable from the core |
| irq_o | output | 1 | Interrupt request to the core |
| wake_o | output | 1 | Wake request for the clock-stopped state |

## Verification
A flag read and a flag set event can fall on the same clock edge. A read-and-clear that wins would lose a key press.

The bench raises an enabled pin and waits two edges. It then issues the flag read so that the read's edge is the edge at which the flag is set. It judges the result by the read data, which is the old value, and by a second read, which must return 1.

The set that a mask write causes on an already active pin is also swept. This runs over every mask value and a fixed active pattern.

// File: rtl/kin_pkg.sv
package kin_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    KA_PINS = 2'd0,
    KA_MASK = 2'd1,
    KA_FLAG = 2'd2,
    KA_RSVD = 2'd3
  } kin_addr_e;
endpackage

// File: rtl/kin_sync.sv
module kin_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/kin_regs.sv
module kin_regs
  import kin_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      lvl_i,
  input  logic              flag_i,
  output logic [W-1:0]      mask_o,
  output logic              mask_wr_o,
  output logic              flag_rd_o,
  output logic [W-1:0]      rdata
);
  logic [W-1:0] mask_q, mask_d;
  logic         mask_en;

  assign mask_en   = wr_en && (addr == KA_MASK);
  assign mask_wr_o = mask_en;
  assign flag_rd_o = rd_en && (addr == KA_FLAG);

  always_comb begin
    mask_d = mask_q;
    if (mask_en) mask_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (addr)
        KA_PINS: rdata = lvl_i;
        KA_MASK: rdata = mask_q;
        KA_FLAG: rdata = {{(W-1){1'b0}}, flag_i};
        default: rdata = '0;
      endcase
    end
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/kin_flag.sv
module kin_flag #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] mask_i,
  input  logic         mask_wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         flag_rd_i,
  output logic         set_evt_o,
  output logic         flag_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise;
  logic         edge_set, wr_set;
  logic         flag_q, flag_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  assign rise     = lvl_i & ~prev_q;
  assign edge_set = |(rise & mask_i);
  assign wr_set   = mask_wr_i && |(wdata_i & lvl_i);
  assign set_evt_o = edge_set || wr_set;

  always_comb begin
    flag_d = flag_q;
    if (flag_rd_i) flag_d = 1'b0;
    if (set_evt_o) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/kin_irq_ctrl.sv
module kin_irq_ctrl
  import kin_pkg::*;
#(
  parameter int unsigned N_PINS      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_PINS-1:0] wdata,
  output logic [N_PINS-1:0] rdata,
  input  logic              gie,
  output logic              irq_o,
  output logic              wake_o
);
  logic [N_PINS-1:0] lvl;
  logic [N_PINS-1:0] mask_q;
  logic              mask_wr, flag_rd, set_evt, flag_q;

  kin_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(lvl)
  );

  kin_regs #(.W(N_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .lvl_i(lvl), .flag_i(flag_q), .mask_o(mask_q),
    .mask_wr_o(mask_wr), .flag_rd_o(flag_rd), .rdata(rdata)
  );

  kin_flag #(.W(N_PINS)) u_flag (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .mask_i(mask_q),
    .mask_wr_i(mask_wr), .wdata_i(wdata), .flag_rd_i(flag_rd),
    .set_evt_o(set_evt), .flag_o(flag_q)
  );

  assign irq_o  = flag_q && gie && (|mask_q);
  assign wake_o = |(lvl & mask_q);
endmodule

// File: rtl/kin_irq_ctrl_chk.sv
module kin_irq_ctrl_chk
  import kin_pkg::*;
#(
  parameter int unsigned N_PINS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [N_PINS-1:0] wdata,
  input logic              gie,
  input logic              irq_o,
  input logic              wake_o,
  input logic [N_PINS-1:0] mask_q,
  input logic              flag_q,
  input logic              set_evt
);
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == KA_MASK) |=> (mask_q == $past(wdata))); // R2

  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == KA_FLAG && !set_evt) |=> !flag_q); // R5

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q); // R6

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (gie && flag_q)); // R7

  AST_WAKE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (mask_q != '0)); // R8
endmodule

bind kin_irq_ctrl kin_irq_ctrl_chk #(.N_PINS(N_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .gie(gie), .irq_o(irq_o), .wake_o(wake_o),
  .mask_q(mask_q), .flag_q(flag_q), .set_evt(set_evt)
);

// File: tb/kin_irq_ctrl_test.sv
module kin_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pin_i = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [3:0] wdata = '0;
  logic [3:0] rdata;
  logic       gie = 1'b0;
  logic       irq_o, wake_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  kin_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .gie(gie),
    .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // read starting at the current negedge; rdata sampled before the edge
  task automatic rd_now(input logic [1:0] a, output logic [3:0] v);
    rd_en = 1'b1; addr = a;
    #1 v = rdata;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [3:0] v);
    @(negedge clk);
    rd_now(a, v);
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  initial begin
    logic [3:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    #1;
    check("R9 irq", {3'b0, irq_o}, 4'h0);
    check("R9 wake", {3'b0, wake_o}, 4'h0);
    check("R1 idle rdata", rdata, 4'h0);
    rd(2'd1, v); check("R9 mask", v, 4'h0);
    rd(2'd2, v); check("R9 flag", v, 4'h0);

    // R1 data sweep and two-edge latency
    for (int p = 0; p < 16; p++) begin
      @(negedge clk); pin_i = p[3:0];
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      rd_now(2'd0, v); check("R1 pins", v, p[3:0]);
    end
    @(negedge clk); pin_i = 4'h0; settle();

    // R2 mask sweep
    for (int m = 0; m < 16; m++) begin
      wr(2'd1, m[3:0]);
      rd(2'd1, v); check("R2 mask", v, m[3:0]);
    end

    // R3 edge sweep over mask and bit
    for (int m = 0; m < 16; m++) begin
      for (int b = 0; b < 4; b++) begin
        @(negedge clk); pin_i = 4'h0; settle();
        wr(2'd1, m[3:0]);
        rd(2'd2, v);
        @(negedge clk); pin_i = 4'h1 << b;
        settle();
        rd(2'd2, v); check("R3 flag", v, {3'b0, m[b]});
      end
    end
    @(negedge clk); pin_i = 4'h0; settle();

    // R4 mask write while pins active
    wr(2'd1, 4'h0);
    @(negedge clk); pin_i = 4'b0101; settle();
    for (int m = 0; m < 16; m++) begin
      wr(2'd1, 4'h0);
      rd(2'd2, v);
      wr(2'd1, m[3:0]);
      rd(2'd2, v); check("R4 flag", v, {3'b0, |(m[3:0] & 4'b0101)});
    end

    // R5 read clears
    wr(2'd1, 4'h0);
    wr(2'd1, 4'b0001);
    rd(2'd2, v); check("R5 first read", v, 4'h1);
    rd(2'd2, v); check("R5 second read", v, 4'h0);

    // R6 set on same edge as read
    @(negedge clk); pin_i = 4'h0; settle();
    wr(2'd1, 4'b0010);
    rd(2'd2, v);
    @(negedge clk); pin_i = 4'b0010;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rd_now(2'd2, v); check("R6 read value", v, 4'h0);
    rd(2'd2, v); check("R6 flag kept", v, 4'h1);

    // R7 irq gating
    wr(2'd1, 4'h0);
    wr(2'd1, 4'b0010);
    @(negedge clk); gie = 1'b0; #1;
    check("R7 gie off", {3'b0, irq_o}, 4'h0);
    gie = 1'b1; #1;
    check("R7 all on", {3'b0, irq_o}, 4'h1);
    wr(2'd1, 4'h0); #1;
    check("R7 mask zero", {3'b0, irq_o}, 4'h0);
    rd(2'd2, v); check("R7 flag still set", v, 4'h1);
    wr(2'd1, 4'b0100); #1;
    check("R7 flag clear", {3'b0, irq_o}, 4'h0);
    gie = 1'b0;

    // R8 wake sweep
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 16; p += 5) begin
        wr(2'd1, m[3:0]);
        @(negedge clk); pin_i = p[3:0];
        @(posedge clk); @(posedge clk);
        #1 check("R8 wake", {3'b0, wake_o}, {3'b0, |(m[3:0] & p[3:0])});
      end
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule